// File: doc/BRIEF.md
# Serial Peripheral Master with Encoded Device Select

This block is a full-duplex serial peripheral master that exchanges one word (8 bits by default) with an addressed device. It uses a single shift register for both directions. Outgoing bits leave from the top on each rising serial-clock edge. Incoming bits enter at the bottom on each falling edge. After the last pulse, the register holds the device's word.

The host starts a transfer with three inputs applied together: a one-cycle start strobe, the byte to send and a 4-bit device number. The 4-bit number is driven unchanged on four select lines for the whole word. An external 4-to-16 decoder turns it into sixteen individual enables. A separate active-low frame strobe marks the word. The serial clock is a division of the system clock and idles low.

A pause input freezes the transfer in place. While it is held high the serial clock does not move, so the peripheral sees no edge and loses nothing. Completion is reported by a one-cycle done pulse, which carries no acknowledgement from the peripheral.

Top module: `spi_enc_master`

## Requirements
- R1: After reset the serial clock is low, the frame strobe is high, done, busy and the data output are low, and the select code is 0.
- R2: A start strobe seen while idle captures the transmit word and the device number. The number appears on the select lines in the next cycle and stays unchanged until the word ends.
- R3: The frame strobe goes low in the cycle after the start is accepted. The first rising serial-clock edge follows HALF_DIV system cycles later.
- R4: Each serial-clock level lasts HALF_DIV unpaused system cycles. The clock is low whenever the frame strobe is high, and a word has exactly WORD_W high pulses.
- R5: The data output changes only together with a rising serial-clock edge and carries the transmit word most significant bit first.
- R6: The data input is sampled at each falling serial-clock edge and enters bit 0 of the shift register. After the last falling edge the received word equals the peripheral's word.
- R7: done is high for exactly one cycle, in the same cycle as the last falling serial-clock edge. In that cycle the frame strobe returns high and the received-word output is valid.
- R8: While pause is high during a transfer, the serial clock, the data output and the bit position hold their values. When pause is released the word resumes and completes with no bit lost.
- R9: A start strobe arriving while a word is in progress is ignored, along with its data and device number.
- R10: busy is high from the cycle after an accepted start up to and including the cycle before done, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| dev_num_i | input | 4 | Device number for the external decoder |
| tx_word_i | input | 8 | Word to transmit |
| pause_i | input | 1 | Freezes serial clock and bit progress while high |
| miso_i | input | 1 | Serial data from the peripheral |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the peripheral |
| frame_n_o | output | 1 | Active-low word strobe |
| sel_code_o | output | 4 | Encoded device select lines |
| rx_word_o | output | 8 | Received word, valid with done |
| done_o | output | 1 | One-cycle end-of-word pulse |
| busy_o | output | 1 | Transfer in progress |

## Verification
An accepted start shows up one cycle later on the frame strobe, busy and the select lines. The first rising serial-clock edge follows HALF_DIV cycles after that. Every further edge comes after HALF_DIV more unpaused cycles, and done with the received word arrives at the sixteenth edge.

The bench's reference model advances on the same system-clock edge as the design and counts paused cycles as no progress. Every output is compared with the model on the falling system-clock edge, so each result is checked in the exact cycle it is due. A behavioural peripheral shifts in the other direction, and at each done pulse its captured word and the master's received word are compared with the words that were sent.

// File: rtl/spi_enc_pkg.sv
package spi_enc_pkg;

  // Word sequencing phases: idle, half-period lead-in, clock high, clock low
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } spi_phase_e;

endpackage

// File: rtl/spi_enc_div.sv
module spi_enc_div #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic hold_i,
  output logic tick_o
);

  localparam int CNT_W = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == LAST_CNT);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (!hold_i) begin
      cnt_d = at_end ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = run_i & ~hold_i & at_end;

endmodule

// File: rtl/spi_enc_shreg.sv
module spi_enc_shreg #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] word_o,
  output logic              last_bit_o
);

  localparam int BIT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              mosi_q, mosi_d;

  assign last_bit_o = (bit_q == LAST_BIT);

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    mosi_d = mosi_q;
    if (load_i) begin
      sh_d  = load_word_i;
      bit_d = '0;
    end else if (rise_i) begin
      mosi_d = sh_q[WORD_W-1];
      sh_d   = {sh_q[WORD_W-2:0], 1'b0};
    end else if (fall_i) begin
      sh_d[0] = miso_i;
      if (last_bit_o) begin
        bit_d  = '0;
        mosi_d = 1'b0;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      mosi_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      mosi_q <= mosi_d;
    end
  end

  assign mosi_o = mosi_q;
  assign word_o = sh_q;

endmodule

// File: rtl/spi_enc_fsm.sv
module spi_enc_fsm
  import spi_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  input  logic last_bit_i,
  output logic accept_o,
  output logic rise_o,
  output logic fall_o,
  output logic sclk_o,
  output logic busy_o,
  output logic done_o
);

  spi_phase_e st_q, st_d;
  logic       done_q, done_d;

  assign accept_o = (st_q == ST_IDLE) & start_i;
  assign rise_o   = tick_i & ((st_q == ST_LEAD) | (st_q == ST_LOW));
  assign fall_o   = tick_i & (st_q == ST_HIGH);

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_LEAD;
      ST_LEAD: if (tick_i)  st_d = ST_HIGH;
      ST_HIGH: begin
        if (tick_i) begin
          if (last_bit_i) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            st_d = ST_LOW;
          end
        end
      end
      ST_LOW:  if (tick_i)  st_d = ST_HIGH;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  assign sclk_o = (st_q == ST_HIGH);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/spi_enc_master.sv
module spi_enc_master #(
  parameter int WORD_W   = 8,
  parameter int SEL_W    = 4,
  parameter int HALF_DIV = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SEL_W-1:0]  dev_num_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              pause_i,
  input  logic              miso_i,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              frame_n_o,
  output logic [SEL_W-1:0]  sel_code_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              done_o,
  output logic              busy_o
);

  logic accept, rise, fall, tick, last_bit, busy;
  logic [SEL_W-1:0] sel_q, sel_d;

  spi_enc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tick_i     (tick),
    .last_bit_i (last_bit),
    .accept_o   (accept),
    .rise_o     (rise),
    .fall_o     (fall),
    .sclk_o     (sclk_o),
    .busy_o     (busy),
    .done_o     (done_o)
  );

  spi_enc_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .hold_i (pause_i),
    .tick_o (tick)
  );

  spi_enc_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .load_word_i (tx_word_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .word_o      (rx_word_o),
    .last_bit_o  (last_bit)
  );

  always_comb begin
    sel_d = sel_q;
    if (accept) sel_d = dev_num_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else begin
      sel_q <= sel_d;
    end
  end

  assign sel_code_o = sel_q;
  assign frame_n_o  = ~busy;
  assign busy_o     = busy;

endmodule

// File: rtl/spi_enc_master_chk.sv
module spi_enc_master_chk #(
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pause_i,
  input logic             sclk_o,
  input logic             mosi_o,
  input logic             frame_n_o,
  input logic [SEL_W-1:0] sel_code_o,
  input logic             done_o
);

  // R2: select lines hold while the frame stays active
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n_o && $past(!frame_n_o)) |-> $stable(sel_code_o));

  // R4: serial clock is low outside a frame
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_o |-> !sclk_o);

  // R5: data output moves only with a rising serial clock
  p_mosi_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n_o && !$stable(mosi_o)) |-> $rose(sclk_o));

  // R7: done lasts one cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: frame release coincides with done
  p_frame_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n_o) |-> done_o);

  // R8: pause freezes serial clock and data
  p_pause_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_i && !frame_n_o) |=> ($stable(sclk_o) && $stable(mosi_o)));

endmodule

bind spi_enc_master spi_enc_master_chk #(.SEL_W(SEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pause_i    (pause_i),
  .sclk_o     (sclk_o),
  .mosi_o     (mosi_o),
  .frame_n_o  (frame_n_o),
  .sel_code_o (sel_code_o),
  .done_o     (done_o)
);

// File: tb/test_spi_enc_master.sv
`timescale 1ns/1ps
module test_spi_enc_master;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] dev_num_i = '0;
  logic [7:0] tx_word_i = '0;
  logic       pause_i = 1'b0;
  logic       miso_i = 1'b0;
  logic       sclk_o, mosi_o, frame_n_o, done_o, busy_o;
  logic [3:0] sel_code_o;
  logic [7:0] rx_word_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit pause_en = 0;

  always #10 clk = ~clk;

  spi_enc_master #(.WORD_W(8), .SEL_W(4), .HALF_DIV(HALF)) i_spi_enc_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dev_num_i(dev_num_i),
    .tx_word_i(tx_word_i), .pause_i(pause_i), .miso_i(miso_i),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .frame_n_o(frame_n_o),
    .sel_code_o(sel_code_o), .rx_word_o(rx_word_o), .done_o(done_o),
    .busy_o(busy_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: counts edges of the serial word
  int   m_busy, m_cnt, m_edges, m_sclk, m_done, m_mosi, m_sel;
  logic [7:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_edges = 0; m_sclk = 0; m_done = 0;
      m_mosi = 0; m_sel = 0; m_word = 8'h00;
    end else begin
      m_done = 0;
      if (m_busy == 0) begin
        if (start_i) begin
          m_busy = 1; m_cnt = 0; m_edges = 0;
          m_word = tx_word_i; m_sel = dev_num_i;
        end
      end else if (!pause_i) begin
        if (m_cnt == HALF - 1) begin
          m_cnt = 0;
          if (m_edges % 2 == 0) begin
            m_sclk = 1; m_mosi = m_word[7]; m_word = {m_word[6:0], 1'b0};
          end else begin
            m_sclk = 0; m_word[0] = miso_i;
          end
          m_edges++;
          if (m_edges == 16) begin
            m_busy = 0; m_done = 1; m_mosi = 0;
          end
        end else begin
          m_cnt++;
        end
      end
    end
  end

  // Behavioural peripheral
  logic [7:0] slv_tx = 8'h00;
  logic [7:0] slv_rx = 8'h00;
  int   slv_k = 0;
  logic prev_sclk = 1'b0;

  always @(negedge clk) begin
    if (prev_sclk && !sclk_o) slv_k++;
    if (!prev_sclk && sclk_o) slv_rx = {slv_rx[6:0], mosi_o};
    prev_sclk = sclk_o;
    if (frame_n_o) slv_k = 0;
    miso_i = (slv_k < 8) ? slv_tx[7 - slv_k] : 1'b0;
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4", "sclk", sclk_o, m_sclk);
      check("R3", "frame_n", frame_n_o, m_busy ? 0 : 1);
      check("R10", "busy", busy_o, m_busy);
      check("R5", "mosi", mosi_o, m_mosi);
      check("R2", "sel_code", sel_code_o, m_sel);
      check("R7", "done", done_o, m_done);
      if (m_done) check("R6", "rx_word", rx_word_o, m_word);
    end
  end

  // Pause driver
  always @(negedge clk) begin
    if (pause_en) pause_i <= ($urandom % 3) == 0;
    else          pause_i <= 1'b0;
  end

  task automatic run_word(input logic [7:0] tx, input logic [3:0] dev,
                          input logic [7:0] sb, input bit poke);
    slv_tx = sb;
    slv_rx = 8'h00;
    @(negedge clk);
    start_i = 1'b1; tx_word_i = tx; dev_num_i = dev;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (7) @(negedge clk);
      start_i = 1'b1; tx_word_i = ~tx; dev_num_i = ~dev;  // R9: ignored
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < 2000; i++) begin
      if (done_o) break;
      @(negedge clk);
    end
    check("R7", "done seen", done_o, 1);
    check("R6", "master rx equals peripheral word", rx_word_o, sb);
    check(poke ? "R9" : "R5", "peripheral captured tx", slv_rx, tx);
    if (poke) check("R9", "select kept", sel_code_o, dev);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", "sclk", sclk_o, 0);
    check("R1", "frame_n", frame_n_o, 1);
    check("R1", "done", done_o, 0);
    check("R1", "busy", busy_o, 0);
    check("R1", "mosi", mosi_o, 0);
    check("R1", "sel", sel_code_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_word(8'hAA, 4'h3, 8'h55, 0);
    run_word(8'h80, 4'hF, 8'h01, 0);
    run_word(8'h01, 4'h0, 8'hFF, 0);
    run_word(8'h00, 4'h9, 8'h00, 0);
    run_word(8'hC3, 4'h6, 8'h3C, 1);
    pause_en = 1;  // R8
    run_word(8'h5A, 4'hA, 8'hA5, 0);
    run_word(8'hE7, 4'h2, 8'h18, 1);
    pause_en = 0;
    for (int n = 0; n < 6; n++) begin
      run_word(8'($urandom), 4'($urandom), 8'($urandom), 0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule